// File: doc/BRIEF.md
# Multi-Port GPIO Register Block with APB Access

This block is an APB slave that holds the software-visible state of up to four general-purpose I/O ports. Each port is up to 32 bits wide. For each port it keeps an output-value register and a direction register, and it offers a read-only view of the pin levels.

Pin inputs pass through a two-flop synchronizer before they can be read. The block presents output values and output enables to the pad ring, which is outside this block.

The first port also owns the configuration for a separate pin-interrupt unit: enable, mask, type, polarity and debounce-enable words. The block drives these words straight to that unit. It returns the unit's status word on reads, and it turns a write to the acknowledge offset into a one-cycle clear pulse.

Every transfer completes without wait states and never signals an error.

Top module: `gpio_regblk`

## Requirements
- R1: After reset, every writable register is zero: all outputs, output enables, interrupt configuration outputs and the acknowledge pulse read 0. With the pins and the status input at 0, every word offset from 0x00 to 0x7C reads 0.
- R2: Port p (p = 0..NUM_PORTS-1) has its output-value register at byte offset 0x0C*p and its direction register at 0x0C*p+4. Both are read/write and read back the last value written. Port p's slice of pin_out_o equals its output-value register and its slice of pin_oe_o equals its direction register (1 = drive, 0 = high impedance). A write to one port leaves the other ports unchanged.
- R3: The pin-level register of port p sits at 0x50+4*p. It returns the pin level sampled by two flops: a change on pin_i is not visible after one rising clock edge and is visible after two. Writes to it have no effect.
- R4: The interrupt configuration words are read/write and drive their outputs directly: enable at 0x30 (irq_en_o), mask at 0x34 (irq_mask_o), type at 0x38 (irq_edge_o), polarity at 0x3C (irq_pol_o), debounce enable at 0x48 (dbc_en_o).
- R5: Offset 0x40 reads the irq_status_i input. Writes to it have no effect on any output.
- R6: A write to 0x4C drives the written bits on irq_ack_o for exactly one cycle, starting at the write's access edge. irq_ack_o is zero otherwise, and reads of 0x4C return 0.
- R7: Unmapped offsets, including the registers of ports at or above NUM_PORTS, read 0, and writes to them change no output.
- R8: Register bits at or above PORT_WIDTH are not stored and read as 0.
- R9: pready_o is always 1 and pslverr_o is always 0. A register is written only in the access phase (psel_i and penable_i both high); a setup phase alone changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB access phase |
| pwrite_i | input | 1 | APB write (1) or read (0) |
| paddr_i | input | ADDR_W | APB byte address; bits [1:0] ignored |
| pwdata_i | input | 32 | APB write data |
| prdata_o | output | 32 | APB read data, zero when not reading |
| pready_o | output | 1 | Always 1 |
| pslverr_o | output | 1 | Always 0 |
| pin_i | input | NUM_PORTS*PORT_WIDTH | Raw pin levels, port p at bits [p*PORT_WIDTH +: PORT_WIDTH] |
| pin_out_o | output | NUM_PORTS*PORT_WIDTH | Pin output values |
| pin_oe_o | output | NUM_PORTS*PORT_WIDTH | Pin output enables |
| irq_en_o | output | PORT_WIDTH | Interrupt enable word |
| irq_mask_o | output | PORT_WIDTH | Interrupt mask word |
| irq_edge_o | output | PORT_WIDTH | Interrupt type word |
| irq_pol_o | output | PORT_WIDTH | Interrupt polarity word |
| irq_status_i | input | PORT_WIDTH | Status from the interrupt unit |
| dbc_en_o | output | PORT_WIDTH | Debounce enable word |
| irq_ack_o | output | PORT_WIDTH | One-cycle acknowledge pulse |

## Verification
The bench builds the block with NUM_PORTS = 3 and PORT_WIDTH = 8.

The 8-bit width makes full sweeps affordable:
- All 256 output and direction values on the first port are written and read back.
- All 256 pin patterns on the first port's pin-level register are applied, each checked one edge and two edges after the change.

The missing fourth port leaves its offsets unmapped, so they can be checked to read zero. The narrow width also leaves bits 31:8 of every register unused, so wide writes show that those bits are dropped.

// File: rtl/gpio_regblk_pkg.sv
`timescale 1ns/1ps
package gpio_regblk_pkg;
  localparam int unsigned MAX_PORTS = 4;
  localparam int unsigned BUS_W     = 32;

  localparam logic [31:0] PORT_STRIDE = 32'h0C;
  localparam logic [31:0] DOUT_BASE   = 32'h00;
  localparam logic [31:0] DDIR_BASE   = 32'h04;
  localparam logic [31:0] EXT_BASE    = 32'h50;
  localparam logic [31:0] EXT_STRIDE  = 32'h04;
  localparam logic [31:0] OFF_STATUS  = 32'h40;
  localparam logic [31:0] OFF_ACK     = 32'h4C;

  typedef enum int unsigned {
    CFG_EN   = 0,
    CFG_MASK = 1,
    CFG_EDGE = 2,
    CFG_POL  = 3,
    CFG_DBC  = 4
  } cfg_idx_e;

  localparam int unsigned NUM_CFG = 5;

  function automatic logic [31:0] cfg_offset(input int unsigned idx);
    case (idx)
      CFG_EN:   return 32'h30;
      CFG_MASK: return 32'h34;
      CFG_EDGE: return 32'h38;
      CFG_POL:  return 32'h3C;
      default:  return 32'h48;
    endcase
  endfunction

  // word-granular match, byte lanes ignored
  function automatic logic word_hit(input logic [31:0] addr, input logic [31:0] off);
    return (addr >> 2) == (off >> 2);
  endfunction
endpackage

// File: rtl/gpio_sync2.sv
`timescale 1ns/1ps
module gpio_sync2 #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] dout_o
);
  logic [W-1:0] meta_q, sync_q;
  logic [1:0]   age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= din_i;
      sync_q <= meta_q;
    end
  end

  assign dout_o = sync_q;

  // settle counter used only by the latency check
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            age_q <= 2'd0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  assert_sync_latency_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd2) |-> (dout_o == $past(din_i, 2)));
endmodule

// File: rtl/gpio_port_slice.sv
`timescale 1ns/1ps
module gpio_port_slice
  import gpio_regblk_pkg::*;
#(
  parameter int unsigned IDX = 0,
  parameter int unsigned W   = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [31:0]  addr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] out_o,
  output logic [W-1:0] oe_o,
  output logic [31:0]  rdata_o
);
  localparam logic [31:0] OFF_DOUT = DOUT_BASE + IDX * PORT_STRIDE;
  localparam logic [31:0] OFF_DDIR = DDIR_BASE + IDX * PORT_STRIDE;
  localparam logic [31:0] OFF_EXT  = EXT_BASE + IDX * EXT_STRIDE;

  logic         hit_dout, hit_ddir, hit_ext;
  logic [W-1:0] dout_q, ddir_q, pin_s;

  assign hit_dout = word_hit(addr_i, OFF_DOUT);
  assign hit_ddir = word_hit(addr_i, OFF_DDIR);
  assign hit_ext  = word_hit(addr_i, OFF_EXT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q <= '0;
      ddir_q <= '0;
    end else if (wr_en_i) begin
      if (hit_dout) dout_q <= wdata_i;
      if (hit_ddir) ddir_q <= wdata_i;
    end
  end

  gpio_sync2 #(.W(W)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .din_i  (pin_i),
    .dout_o (pin_s)
  );

  assign out_o = dout_q;
  assign oe_o  = ddir_q;

  always_comb begin
    if (hit_dout)      rdata_o = 32'(dout_q);
    else if (hit_ddir) rdata_o = 32'(ddir_q);
    else if (hit_ext)  rdata_o = 32'(pin_s);
    else               rdata_o = '0;
  end

  assert_dout_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && hit_dout) |=> (out_o == $past(wdata_i)));
  assert_dout_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && hit_dout) |=> $stable(out_o));
  assert_ddir_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && hit_ddir) |=> $stable(oe_o));
endmodule

// File: rtl/gpio_irq_cfg.sv
`timescale 1ns/1ps
module gpio_irq_cfg
  import gpio_regblk_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [31:0]  addr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] status_i,
  output logic [W-1:0] en_o,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] edge_o,
  output logic [W-1:0] pol_o,
  output logic [W-1:0] dbc_o,
  output logic [W-1:0] ack_o,
  output logic [31:0]  rdata_o
);
  logic [W-1:0]       cfg_q   [NUM_CFG];
  logic [NUM_CFG-1:0] cfg_hit;
  logic               hit_sts, hit_ack;
  logic [W-1:0]       ack_q;

  for (genvar i = 0; i < NUM_CFG; i++) begin : g_cfg
    assign cfg_hit[i] = word_hit(addr_i, cfg_offset(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  cfg_q[i] <= '0;
      else if (wr_en_i && cfg_hit[i]) cfg_q[i] <= wdata_i;
    end

    assert_cfg_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_en_i && cfg_hit[i]) |=> $stable(cfg_q[i]));
  end

  assign hit_sts = word_hit(addr_i, OFF_STATUS);
  assign hit_ack = word_hit(addr_i, OFF_ACK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_q <= '0;
    else         ack_q <= (wr_en_i && hit_ack) ? wdata_i : '0;
  end

  assign en_o   = cfg_q[CFG_EN];
  assign mask_o = cfg_q[CFG_MASK];
  assign edge_o = cfg_q[CFG_EDGE];
  assign pol_o  = cfg_q[CFG_POL];
  assign dbc_o  = cfg_q[CFG_DBC];
  assign ack_o  = ack_q;

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_CFG; i++)
      if (cfg_hit[i]) rdata_o = 32'(cfg_q[i]);
    if (hit_sts) rdata_o = 32'(status_i);
  end

  assert_ack_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && hit_ack) |=> (ack_o == '0));
  assert_ack_onehit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cfg_hit, hit_sts, hit_ack}));
endmodule

// File: rtl/gpio_regblk.sv
`timescale 1ns/1ps
module gpio_regblk
  import gpio_regblk_pkg::*;
#(
  parameter int unsigned NUM_PORTS  = 4,
  parameter int unsigned PORT_WIDTH = 32,
  parameter int unsigned ADDR_W     = 7
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            psel_i,
  input  logic                            penable_i,
  input  logic                            pwrite_i,
  input  logic [ADDR_W-1:0]               paddr_i,
  input  logic [BUS_W-1:0]                pwdata_i,
  output logic [BUS_W-1:0]                prdata_o,
  output logic                            pready_o,
  output logic                            pslverr_o,
  input  logic [NUM_PORTS*PORT_WIDTH-1:0] pin_i,
  output logic [NUM_PORTS*PORT_WIDTH-1:0] pin_out_o,
  output logic [NUM_PORTS*PORT_WIDTH-1:0] pin_oe_o,
  output logic [PORT_WIDTH-1:0]           irq_en_o,
  output logic [PORT_WIDTH-1:0]           irq_mask_o,
  output logic [PORT_WIDTH-1:0]           irq_edge_o,
  output logic [PORT_WIDTH-1:0]           irq_pol_o,
  input  logic [PORT_WIDTH-1:0]           irq_status_i,
  output logic [PORT_WIDTH-1:0]           dbc_en_o,
  output logic [PORT_WIDTH-1:0]           irq_ack_o
);
  localparam int unsigned NSRC = NUM_PORTS + 1;

  logic                  wr_en, rd_en;
  logic [31:0]           addr;
  logic [PORT_WIDTH-1:0] wdata;
  logic [31:0]           src_rdata [NSRC];
  logic [31:0]           rd_mux;

  assign wr_en = psel_i && penable_i && pwrite_i;
  assign rd_en = psel_i && !pwrite_i;
  assign addr  = 32'(paddr_i);
  assign wdata = pwdata_i[PORT_WIDTH-1:0];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    gpio_port_slice #(.IDX(p), .W(PORT_WIDTH)) u_slice (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_en_i (wr_en),
      .addr_i  (addr),
      .wdata_i (wdata),
      .pin_i   (pin_i[p*PORT_WIDTH +: PORT_WIDTH]),
      .out_o   (pin_out_o[p*PORT_WIDTH +: PORT_WIDTH]),
      .oe_o    (pin_oe_o[p*PORT_WIDTH +: PORT_WIDTH]),
      .rdata_o (src_rdata[p])
    );
  end

  gpio_irq_cfg #(.W(PORT_WIDTH)) u_irq_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .addr_i   (addr),
    .wdata_i  (wdata),
    .status_i (irq_status_i),
    .en_o     (irq_en_o),
    .mask_o   (irq_mask_o),
    .edge_o   (irq_edge_o),
    .pol_o    (irq_pol_o),
    .dbc_o    (dbc_en_o),
    .ack_o    (irq_ack_o),
    .rdata_o  (src_rdata[NUM_PORTS])
  );

  // decodes are disjoint, so an OR tree is enough
  always_comb begin
    rd_mux = '0;
    for (int s = 0; s < NSRC; s++) rd_mux |= src_rdata[s];
  end

  assign prdata_o  = rd_en ? rd_mux : '0;
  assign pready_o  = 1'b1;
  assign pslverr_o = 1'b0;

  assert_setup_nowrite_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psel_i && !penable_i) |=> ($stable(pin_out_o) && $stable(pin_oe_o)));
  assert_upper_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((64'(prdata_o) >> PORT_WIDTH) == 64'd0));
  assert_idle_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !psel_i |=> ($stable(pin_out_o) && $stable(irq_en_o) && (irq_ack_o == '0)));
endmodule

// File: tb/gpio_regblk_tb.sv
`timescale 1ns/1ps
module gpio_regblk_tb_top;
  localparam int NP = 3;
  localparam int PW = 8;
  localparam int NB = NP * PW;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [6:0]    paddr = '0;
  logic [31:0]   pwdata = '0;
  logic [31:0]   prdata;
  logic          pready, pslverr;
  logic [NB-1:0] pin_in = '0;
  logic [NB-1:0] pin_out, pin_oe;
  logic [PW-1:0] irq_en, irq_mask, irq_edge, irq_pol, dbc_en, irq_ack;
  logic [PW-1:0] irq_sts = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [NB-1:0] exp_out = '0;
  logic [NB-1:0] exp_oe  = '0;

  always #2.5 clk = ~clk;

  gpio_regblk #(.NUM_PORTS(NP), .PORT_WIDTH(PW), .ADDR_W(7)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata),
    .pready_o(pready), .pslverr_o(pslverr), .pin_i(pin_in), .pin_out_o(pin_out),
    .pin_oe_o(pin_oe), .irq_en_o(irq_en), .irq_mask_o(irq_mask),
    .irq_edge_o(irq_edge), .irq_pol_o(irq_pol), .irq_status_i(irq_sts),
    .dbc_en_o(dbc_en), .irq_ack_o(irq_ack)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a negedge, returns at a negedge after the access edge
  task automatic apb_wr(input logic [6:0] a, input logic [31:0] d);
    paddr = a; pwdata = d; pwrite = 1'b1; psel = 1'b1; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_rd(input logic [6:0] a, output logic [31:0] d);
    paddr = a; pwrite = 1'b0; psel = 1'b1; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    #1;
    d = prdata;
    if (!pready || pslverr) chk("R9 ready/err", {30'd0, pready, pslverr}, 32'd2);
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [6:0] a, input logic [31:0] exp);
    logic [31:0] d;
    apb_rd(a, d);
    chk(req, d, exp);
  endtask

  // pin change with read started in the same cycle: old after one edge, new after two
  task automatic ext_latency(input int p, input logic [7:0] v, input logic [7:0] old);
    pin_in[p*PW +: PW] = v;
    paddr = 7'(32'h50 + 4 * p); pwrite = 1'b0; psel = 1'b1; penable = 1'b0;
    @(negedge clk);
    chk("R3 one edge", prdata, {24'd0, old});
    penable = 1'b1;
    @(negedge clk);
    chk("R3 two edges", prdata, {24'd0, v});
    psel = 1'b0; penable = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 out", 32'(pin_out), 32'd0);
    chk("R1 oe", 32'(pin_oe), 32'd0);
    chk("R1 irq cfg", {irq_en, irq_mask, irq_edge, irq_pol}, 32'd0);
    chk("R1 dbc/ack", {16'd0, dbc_en, irq_ack}, 32'd0);
    for (int w = 0; w < 32; w++) rd_chk("R1 offset read", 7'(w * 4), 32'd0);

    // R2 exhaustive on port 0
    for (int v = 0; v < 256; v++) begin
      apb_wr(7'h00, 32'(v));
      apb_wr(7'h04, 32'(~v & 8'hFF));
      exp_out[7:0] = 8'(v);
      exp_oe[7:0]  = 8'(~v);
      chk("R2 out port0", 32'(pin_out), 32'(exp_out));
      chk("R2 oe port0", 32'(pin_oe), 32'(exp_oe));
      rd_chk("R2 rd dout0", 7'h00, 32'(v));
      rd_chk("R2 rd ddir0", 7'h04, 32'(~v & 8'hFF));
    end
    // R2 other ports, port isolation
    for (int p = 1; p < NP; p++) begin
      for (int k = 0; k < 16; k++) begin
        logic [7:0] v;
        v = 8'(k * 37 + p * 11);
        apb_wr(7'(12 * p), {24'hFFFFFF, v});
        apb_wr(7'(12 * p + 4), 32'(v ^ 8'h5A));
        exp_out[p*PW +: PW] = v;
        exp_oe[p*PW +: PW]  = v ^ 8'h5A;
        chk("R2 out all ports", 32'(pin_out), 32'(exp_out));
        chk("R2 oe all ports", 32'(pin_oe), 32'(exp_oe));
        rd_chk("R2 rd dout", 7'(12 * p), 32'(v));
        rd_chk("R2 rd ddir", 7'(12 * p + 4), 32'(v ^ 8'h5A));
      end
    end

    // R8 upper bits dropped
    apb_wr(7'h00, 32'hFFFF_FF3C);
    exp_out[7:0] = 8'h3C;
    rd_chk("R8 upper bits", 7'h00, 32'h3C);
    chk("R8 out", 32'(pin_out), 32'(exp_out));

    // R3 exhaustive on port 0, patterns on others
    begin
      logic [7:0] old;
      old = 8'h00;
      for (int v = 1; v < 257; v++) begin
        ext_latency(0, 8'(v), old);
        old = 8'(v);
      end
      for (int p = 1; p < NP; p++) begin
        old = 8'h00;
        for (int k = 0; k < 8; k++) begin
          ext_latency(p, 8'(k * 29 + 3 + p), old);
          old = 8'(k * 29 + 3 + p);
        end
      end
      apb_wr(7'h50, 32'hFFFF_FFFF);
      apb_wr(7'h54, 32'hFFFF_FFFF);
      rd_chk("R3 write ignored", 7'h50, 32'(pin_in[7:0]));
      rd_chk("R3 write ignored p1", 7'h54, 32'(pin_in[15:8]));
      chk("R3 no side effect out", 32'(pin_out), 32'(exp_out));
      chk("R3 no side effect oe", 32'(pin_oe), 32'(exp_oe));
    end

    // R4 interrupt configuration words
    apb_wr(7'h30, 32'h11);
    apb_wr(7'h34, 32'h22);
    apb_wr(7'h38, 32'h44);
    apb_wr(7'h3C, 32'h88);
    apb_wr(7'h48, 32'hF0);
    chk("R4 en", 32'(irq_en), 32'h11);
    chk("R4 mask", 32'(irq_mask), 32'h22);
    chk("R4 edge", 32'(irq_edge), 32'h44);
    chk("R4 pol", 32'(irq_pol), 32'h88);
    chk("R4 dbc", 32'(dbc_en), 32'hF0);
    rd_chk("R4 rd en", 7'h30, 32'h11);
    rd_chk("R4 rd mask", 7'h34, 32'h22);
    rd_chk("R4 rd edge", 7'h38, 32'h44);
    rd_chk("R4 rd pol", 7'h3C, 32'h88);
    rd_chk("R4 rd dbc", 7'h48, 32'hF0);

    // R5 status pass-through, writes ignored
    for (int k = 0; k < 16; k++) begin
      irq_sts = 8'(k * 17);
      rd_chk("R5 status", 7'h40, 32'(k * 17 & 8'hFF));
    end
    apb_wr(7'h40, 32'hFF);
    chk("R5 write no effect", {irq_en, irq_mask, irq_edge, irq_pol}, 32'h11224488);
    chk("R5 write no effect ack", 32'(irq_ack), 32'd0);

    // R6 acknowledge pulse
    apb_wr(7'h4C, 32'hA5);
    chk("R6 ack pulse", 32'(irq_ack), 32'hA5);
    @(negedge clk);
    chk("R6 ack cleared", 32'(irq_ack), 32'd0);
    rd_chk("R6 ack reads zero", 7'h4C, 32'd0);
    chk("R6 ack after read", 32'(irq_ack), 32'd0);

    // R7 unmapped / absent port
    apb_wr(7'h24, 32'hFF);
    apb_wr(7'h28, 32'hFF);
    apb_wr(7'h44, 32'hFF);
    apb_wr(7'h60, 32'hFF);
    chk("R7 out unchanged", 32'(pin_out), 32'(exp_out));
    chk("R7 oe unchanged", 32'(pin_oe), 32'(exp_oe));
    rd_chk("R7 rd 0x24", 7'h24, 32'd0);
    rd_chk("R7 rd 0x28", 7'h28, 32'd0);
    rd_chk("R7 rd 0x44", 7'h44, 32'd0);
    rd_chk("R7 rd 0x5C", 7'h5C, 32'd0);
    rd_chk("R7 rd 0x7C", 7'h7C, 32'd0);

    // R9 setup phase alone writes nothing
    paddr = 7'h00; pwdata = 32'h99; pwrite = 1'b1; psel = 1'b1; penable = 1'b0;
    @(negedge clk);
    psel = 1'b0; pwrite = 1'b0;
    @(negedge clk);
    chk("R9 setup only", 32'(pin_out), 32'(exp_out));
    chk("R9 pready", {31'd0, pready}, 32'd1);
    chk("R9 pslverr", {31'd0, pslverr}, 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule